// File: doc/BRIEF.md
# Block framing regenerator from valid

This block rebuilds stream framing for a data path that carries only data and a valid strobe. A processing function with a long or unknown latency needs no delay line for framing metadata. Downstream of that function, the block counts valid samples and recreates four framing outputs: start of block, end of block, sync, and a block sequence number (BSN). It is intended for latencies that span many blocks or one or more sync intervals.

A timestamp is captured at the input of the processing chain and presented on `globalBsn`. A parameter selects one of two ways to pass it on:
- **At sync only:** the BSN is loaded from `globalBsn` at each sync, and a local BSN counts up by one at every other start of block.
- **At every start of block:** the BSN is loaded from `globalBsn` at every start of block.

A synchronous enable restarts the counting. After it, the first valid sample opens a fresh sync interval. All outputs are registered and appear one cycle after the valid sample that causes them.

Top module: `frame_regen`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `outValid`, `outSop`, `outEop` and `outSync` are 0 and `outBsn` is 0.
- R2: `outSop` is 1 for the first valid sample of each block. A block is `BLOCK_SIZE` accepted samples, counted from the first accepted sample after reset or re-enable.
- R3: `outEop` is 1 for the `BLOCK_SIZE`-th accepted sample of each block.
- R4: `outSync` is 1 only together with `outSop`, on the first block of each sync interval. A sync interval is `blocksPerSync` blocks, and a `blocksPerSync` value of 0 behaves as 1.
- R5: At a sync, `outBsn` takes the value of `globalBsn` that was presented with that sample.
- R6: With `BSN_AT_SOP`=0, `outBsn` rises by one at each start of block that is not a sync, and holds its value on all other cycles.
- R7: With `BSN_AT_SOP`=1, `outBsn` takes `globalBsn` at every start of block, and holds its value on all other cycles.
- R8: While `enable` is 0, no output strobe is produced and `outBsn` holds its value. The first accepted sample after `enable` returns is a sync and a start of block.
- R9: A cycle with `inValid`=0 advances no counter and produces no strobe.
- R10: `outValid` equals `inValid` AND `enable` of the previous cycle. Every output is registered and has one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Counting enable; low restarts framing |
| inValid | input | 1 | Valid strobe of the data path |
| blocksPerSync | input | BPS_W | Blocks per sync interval (0 behaves as 1) |
| globalBsn | input | BSN_W | Captured global timestamp |
| outValid | output | 1 | Registered valid |
| outSop | output | 1 | Start of block |
| outEop | output | 1 | End of block |
| outSync | output | 1 | Start of sync interval |
| outBsn | output | BSN_W | Block sequence number, held between updates |

## Verification
Every result is due exactly one clock edge after the input sample that causes it.

The bench drives each new input on a falling edge. On the next falling edge it compares every output with the value its model predicted for the sample driven one cycle before. It then drives the next input.

The model advances its sample and block counts only for accepted samples. It therefore predicts the effect of gaps, re-enables and changes of the interval length in the same cycle the hardware does. Two instances run side by side, one for each BSN mode, so both modes see identical stimulus.

// File: rtl/frame_regen_pkg.sv
package frame_regen_pkg;
  typedef struct packed {
    logic valid;
    logic sop;
    logic eop;
    logic sync;
  } frameStrobe_t;
endpackage

// File: rtl/frame_regen_ctrl.sv
module frame_regen_ctrl
  import frame_regen_pkg::*;
#(
  parameter int BLOCK_SIZE = 4,
  parameter int BPS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             inValid,
  input  logic [BPS_W-1:0] blocksPerSync,
  output frameStrobe_t     strobe
);
  localparam int SAMP_W = (BLOCK_SIZE > 1) ? $clog2(BLOCK_SIZE) : 1;
  localparam logic [SAMP_W-1:0] LAST_SAMP = SAMP_W'(BLOCK_SIZE - 1);

  logic [SAMP_W-1:0] sampCnt;
  logic [BPS_W-1:0]  blkCnt;
  logic              accept;
  logic              lastBlock;

  assign accept    = inValid && enable;
  // A setting of 0 makes every block the last one of its interval.
  assign lastBlock = ({1'b0, blkCnt} + 1'b1) >= {1'b0, blocksPerSync};

  always_comb begin
    strobe.valid = accept;
    strobe.sop   = accept && (sampCnt == '0);
    strobe.eop   = accept && (sampCnt == LAST_SAMP);
    strobe.sync  = accept && (sampCnt == '0) && (blkCnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      sampCnt <= '0;
      blkCnt  <= '0;
    end else if (inValid) begin
      if (sampCnt == LAST_SAMP) begin
        sampCnt <= '0;
        blkCnt  <= lastBlock ? '0 : blkCnt + 1'b1;
      end else begin
        sampCnt <= sampCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/frame_regen_dp.sv
module frame_regen_dp
  import frame_regen_pkg::*;
#(
  parameter int BSN_W = 16,
  parameter bit BSN_AT_SOP = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  frameStrobe_t     strobe,
  input  logic [BSN_W-1:0] globalBsn,
  output logic             outValid,
  output logic             outSop,
  output logic             outEop,
  output logic             outSync,
  output logic [BSN_W-1:0] outBsn
);
  logic [BSN_W-1:0] nextBsn;

  generate
    if (BSN_AT_SOP) begin : g_bsnEverySop
      always_comb begin
        nextBsn = strobe.sop ? globalBsn : outBsn;
      end
    end else begin : g_bsnAtSync
      always_comb begin
        if (strobe.sync)     nextBsn = globalBsn;
        else if (strobe.sop) nextBsn = outBsn + 1'b1;
        else                 nextBsn = outBsn;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSop   <= 1'b0;
      outEop   <= 1'b0;
      outSync  <= 1'b0;
      outBsn   <= '0;
    end else begin
      outValid <= strobe.valid;
      outSop   <= strobe.sop;
      outEop   <= strobe.eop;
      outSync  <= strobe.sync;
      outBsn   <= nextBsn;
    end
  end
endmodule

// File: rtl/frame_regen.sv
module frame_regen
  import frame_regen_pkg::*;
#(
  parameter int BLOCK_SIZE = 4,
  parameter int BPS_W = 8,
  parameter int BSN_W = 16,
  parameter bit BSN_AT_SOP = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             inValid,
  input  logic [BPS_W-1:0] blocksPerSync,
  input  logic [BSN_W-1:0] globalBsn,
  output logic             outValid,
  output logic             outSop,
  output logic             outEop,
  output logic             outSync,
  output logic [BSN_W-1:0] outBsn
);
  frameStrobe_t strobe;

  frame_regen_ctrl #(.BLOCK_SIZE(BLOCK_SIZE), .BPS_W(BPS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .inValid(inValid),
    .blocksPerSync(blocksPerSync), .strobe(strobe)
  );

  frame_regen_dp #(.BSN_W(BSN_W), .BSN_AT_SOP(BSN_AT_SOP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .globalBsn(globalBsn),
    .outValid(outValid), .outSop(outSop), .outEop(outEop),
    .outSync(outSync), .outBsn(outBsn)
  );
endmodule

// File: rtl/frame_regen_chk.sv
module frame_regen_chk #(
  parameter int BSN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             inValid,
  input logic [BSN_W-1:0] globalBsn,
  input logic             outValid,
  input logic             outSop,
  input logic             outEop,
  input logic             outSync,
  input logic [BSN_W-1:0] outBsn
);
  // R4: a sync only comes with a start of block
  assert_sync_with_sop_R4: assert property (@(posedge clk) disable iff (!rstN)
    outSync |-> outSop);

  // R9: strobes only on valid output cycles
  assert_strobe_needs_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outSop || outEop) |-> outValid);

  // R10: output valid traces accepted input one cycle earlier
  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid && enable));

  // R8: disabled cycles produce nothing
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> !outValid);

  // R5: the timestamp at a sync is the captured global value
  assert_sync_bsn_R5: assert property (@(posedge clk) disable iff (!rstN)
    outSync |-> (outBsn == $past(globalBsn)));

  // R6 and R7: the sequence number only moves at a start of block
  assert_bsn_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !outSop |-> $stable(outBsn));
endmodule

bind frame_regen frame_regen_chk #(.BSN_W(BSN_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .inValid(inValid),
  .globalBsn(globalBsn), .outValid(outValid), .outSop(outSop),
  .outEop(outEop), .outSync(outSync), .outBsn(outBsn)
);

// File: tb/sim_frame_regen.sv
`timescale 1ns/1ps
module sim_frame_regen;
  localparam int BS = 4;
  localparam int BPS_W = 8;
  localparam int BSN_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic inValid = 1'b0;
  logic [BPS_W-1:0] bps = 8'd3;
  logic [BSN_W-1:0] gBsn = '0;

  logic v0, s0, e0, y0, v1, s1, e1, y1;
  logic [BSN_W-1:0] b0, b1;

  int checks = 0;
  int errors = 0;

  // model state
  int mSamp = 0;
  int mBlk = 0;
  logic xV, xSop, xEop, xSync;
  logic [BSN_W-1:0] xB0 = '0;
  logic [BSN_W-1:0] xB1 = '0;

  always #2 clk = ~clk;

  frame_regen #(.BLOCK_SIZE(BS), .BPS_W(BPS_W), .BSN_W(BSN_W), .BSN_AT_SOP(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .inValid(inValid),
    .blocksPerSync(bps), .globalBsn(gBsn), .outValid(v0), .outSop(s0),
    .outEop(e0), .outSync(y0), .outBsn(b0)
  );

  frame_regen #(.BLOCK_SIZE(BS), .BPS_W(BPS_W), .BSN_W(BSN_W), .BSN_AT_SOP(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .enable(enable), .inValid(inValid),
    .blocksPerSync(bps), .globalBsn(gBsn), .outValid(v1), .outSop(s1),
    .outEop(e1), .outSync(y1), .outBsn(b1)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit isLastBlock(input int blk, input int setting);
    return (blk + 1) >= setting;
  endfunction

  // check outputs due from the previous sample, then drive and predict the next
  task automatic step(input logic en, input logic v, input logic [BSN_W-1:0] g);
    @(negedge clk);
    chk("R10 outValid", v0, xV);
    chk("R2 outSop", s0, xSop);
    chk("R3 outEop", e0, xEop);
    chk("R4 outSync", y0, xSync);
    chk("R5/R6 outBsn sync-mode", b0, xB0);
    chk("R9 outValid mode1", v1, xV);
    chk("R2 outSop mode1", s1, xSop);
    chk("R7 outBsn sop-mode", b1, xB1);
    enable = en; inValid = v; gBsn = g;
    xV = 1'b0; xSop = 1'b0; xEop = 1'b0; xSync = 1'b0;
    if (!en) begin
      mSamp = 0; mBlk = 0;               // R8 restart
    end else if (v) begin
      xV = 1'b1;
      xSop = (mSamp == 0);
      xEop = (mSamp == BS - 1);
      xSync = xSop && (mBlk == 0);
      if (xSync) xB0 = g;
      else if (xSop) xB0 = xB0 + 1'b1;
      if (xSop) xB1 = g;
      if (xEop) begin
        mSamp = 0;
        mBlk = isLastBlock(mBlk, int'(bps)) ? 0 : mBlk + 1;
      end else begin
        mSamp++;
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    xV = 0; xSop = 0; xEop = 0; xSync = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outValid", v0, 0);
    chk("R1 outBsn", b0, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 outSop after reset", s0, 0);
    chk("R1 outSync after reset", y0, 0);

    // random traffic, three blocks per interval
    bps = 8'd3;
    for (int i = 0; i < 300; i++)
      step(1'b1, ($urandom % 10) < 7, BSN_W'($urandom));
    // R8: disable mid-block, valids ignored while disabled
    step(1'b1, 1'b1, 16'h1111);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 16'h2222);
    // first accepted sample after re-enable is sync + sop
    step(1'b1, 1'b1, 16'h3333);
    step(1'b1, 1'b0, 16'h4444);
    chk("R8 re-enable sync", y0, 1);
    chk("R8 re-enable bsn", b0, 16'h3333);
    // R4: zero setting behaves as one block per interval
    step(1'b0, 1'b0, 16'h0);
    bps = 8'd0;
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, BSN_W'(i + 100));
    step(1'b0, 1'b0, 16'h0);
    bps = 8'd1;
    for (int i = 0; i < 40; i++) step(1'b1, ($urandom % 2) == 0, BSN_W'($urandom));
    // longer interval, back-to-back valid then sparse valid
    step(1'b0, 1'b0, 16'h0);
    bps = 8'd5;
    for (int i = 0; i < 120; i++) step(1'b1, 1'b1, BSN_W'($urandom));
    for (int i = 0; i < 200; i++) step(1'b1, ($urandom % 4) == 0, BSN_W'($urandom));
    // BSN wrap in sync-only mode
    step(1'b0, 1'b0, 16'h0);
    bps = 8'd4;
    step(1'b1, 1'b1, 16'hFFFE);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 16'h0);
    step(1'b1, 1'b0, 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule